// File: doc/BRIEF.md
# CAN Fault Confinement State Tracker

This block keeps the transmit and receive error counters of a CAN node and derives from them the node's fault confinement state. Once per frame the protocol engine beside it pulses one of four strobes: a transmit error, a receive error, a good transmission or a good reception. The tracker moves the counters and reports whether the node is error-active, error-passive or bus-off. It also raises a warning level once either counter goes past the warning limit.

A node in bus-off sits out until the recovery sequence is complete. The bit-level logic pulses `idle_seq` each time it sees a run of eleven recessive bits, and the tracker counts these pulses. When the count finishes, both counters return to zero. What happens next depends on `stop_sel`. With `stop_sel` low, the node goes straight back to error-active. With `stop_sel` high, it parks in a halt state, which `halt_ack` reports. It stays there until software pulses `restart_req`.

The state machine has four states:
- ST_ACTIVE: error-active.
- ST_PASSIVE: error-passive.
- ST_BUSOFF: recovery in progress.
- ST_HALT: stopped after recovery.

It has six transitions:
- go_passive: ST_ACTIVE to ST_PASSIVE.
- back_active: ST_PASSIVE to ST_ACTIVE.
- go_busoff: ST_ACTIVE or ST_PASSIVE to ST_BUSOFF.
- resume: ST_BUSOFF to ST_ACTIVE, when `stop_sel` is low.
- stop: ST_BUSOFF to ST_HALT, when `stop_sel` is high.
- restart: ST_HALT to ST_ACTIVE.

Top module: `can_fc_tracker`

## Requirements
- R1: While `rst_n` is low and after it rises: both counters read 0, `err_active` is 1, and `err_passive`, `bus_off`, `warn` and `halt_ack` are 0.
- R2: In ST_ACTIVE or ST_PASSIVE, `tx_err` adds 8 to `tec` and `rx_err` adds 1 to `rec`. An error strobe takes precedence over the success strobe of the same counter in the same cycle.
- R3: In ST_ACTIVE or ST_PASSIVE, `tx_ok` subtracts 1 from `tec` and `rx_ok` subtracts 1 from `rec`. A counter at 0 stays at 0.
- R4: `warn` is 1 exactly when `tec` > 96 or `rec` > 96.
- R5: The node is error-passive (`err_passive`=1, go_passive) when either counter exceeds 127 and `tec` is at most 255.
- R6: From error-passive, the node returns to error-active (back_active) once both counters are at or below 127.
- R7: When `tec` exceeds 255, `bus_off` becomes 1 (go_busoff). While in bus-off, all four counter strobes are ignored and both counters hold their values.
- R8: In bus-off, the 128th `idle_seq` pulse counted since entry ends recovery. One cycle later both counters read 0 and `bus_off` is 0. Fewer pulses leave the node in bus-off.
- R9: If `stop_sel` is 0 when recovery ends, the node goes to error-active (resume).
- R10: If `stop_sel` is 1 when recovery ends, the node enters halt (stop). In halt, `halt_ack` is 1; `err_active`, `err_passive` and `bus_off` are 0; and counter strobes are ignored. A `restart_req` pulse in halt returns the node to error-active (restart). `restart_req` has no effect in any other state.
- R11: `rec` saturates at 511 and does not wrap.
- R12: Every output changes in the cycle after the clock edge that samples the causing strobe. All outputs come from registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err | input | 1 | Transmit error strobe |
| rx_err | input | 1 | Receive error strobe |
| tx_ok | input | 1 | Successful transmission strobe |
| rx_ok | input | 1 | Successful reception strobe |
| idle_seq | input | 1 | Eleven-recessive-bit run detected |
| restart_req | input | 1 | Software restart from halt |
| stop_sel | input | 1 | 1: halt after bus-off recovery; 0: resume |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| err_active | output | 1 | Node is error-active |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |
| warn | output | 1 | Either counter above the warning limit |
| halt_ack | output | 1 | Node is halted after recovery |

## Verification
Every result of this block is due exactly one clock after the edge that samples the strobe causing it:
- A counter step, a state change and the new `warn` level all appear together.
- The end of recovery shows up one cycle after the edge carrying the 128th `idle_seq` pulse.

The bench drives inputs on falling edges and advances its behavioural model on each rising edge. It compares every output at the next falling edge, so model and design are aligned to that one-cycle latency. The directed checks read the outputs at the falling edge after the last stimulus cycle.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUSOFF  = 2'd2,
        ST_HALT    = 2'd3
    } fc_state_e;

endpackage

// File: rtl/can_fc_errcnt.sv
// Saturating up/down error counter with a gated update and synchronous clear.
module can_fc_errcnt #(
    parameter int W    = 9,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt_nx,
    output logic [W-1:0] cnt_q
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W:0]   STEP_W  = (W+1)'(STEP);

    logic [W:0] sum;

    always_comb begin
        sum    = {1'b0, cnt_q} + STEP_W;
        cnt_nx = cnt_q;
        if (clr) begin
            cnt_nx = '0;
        end else if (en) begin
            if (inc) begin
                cnt_nx = sum[W] ? CNT_MAX : sum[W-1:0];
            end else if (dec && (cnt_q != '0)) begin
                cnt_nx = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end

endmodule

// File: rtl/can_fc_recovery.sv
// Counts idle-run pulses while armed; flags the pulse that completes recovery.
module can_fc_recovery #(
    parameter int SEQS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic seq_pulse,
    output logic done
);

    localparam int CW = $clog2(SEQS + 1);
    localparam logic [CW-1:0] LAST = CW'(SEQS - 1);

    logic [CW-1:0] seen_q;

    assign done = arm && seq_pulse && (seen_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !arm || done) seen_q <= '0;
        else if (seq_pulse)         seen_q <= seen_q + 1'b1;
    end

endmodule

// File: rtl/can_fc_fsm.sv
// Fault confinement state machine and registered status outputs.
module can_fc_fsm
    import can_fc_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec_nx,
    input  logic [CNT_W-1:0] rec_nx,
    input  logic             recov_done,
    input  logic             stop_sel,
    input  logic             restart_req,
    output fc_state_e        state_q,
    output logic             cnt_en,
    output logic             err_active,
    output logic             err_passive,
    output logic             bus_off,
    output logic             warn,
    output logic             halt_ack
);

    localparam logic [CNT_W-1:0] LIM_WARN = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] LIM_PAS  = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] LIM_BO   = CNT_W'(BUSOFF_LIM);

    fc_state_e state_nx;
    logic      over_pas;
    logic      over_bo;

    assign over_pas = (tec_nx > LIM_PAS) || (rec_nx > LIM_PAS);
    assign over_bo  = (tec_nx > LIM_BO);

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (over_bo)        state_nx = ST_BUSOFF;   // go_busoff
                else if (over_pas)  state_nx = ST_PASSIVE;  // go_passive
            end
            ST_PASSIVE: begin
                if (over_bo)        state_nx = ST_BUSOFF;   // go_busoff
                else if (!over_pas) state_nx = ST_ACTIVE;   // back_active
            end
            ST_BUSOFF: begin
                if (recov_done)     state_nx = stop_sel ? ST_HALT : ST_ACTIVE; // stop / resume
            end
            ST_HALT: begin
                if (restart_req)    state_nx = ST_ACTIVE;   // restart
            end
            default:                state_nx = ST_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_nx;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_active  <= 1'b1;
            err_passive <= 1'b0;
            bus_off     <= 1'b0;
            halt_ack    <= 1'b0;
            warn        <= 1'b0;
        end else begin
            err_active  <= (state_nx == ST_ACTIVE);
            err_passive <= (state_nx == ST_PASSIVE);
            bus_off     <= (state_nx == ST_BUSOFF);
            halt_ack    <= (state_nx == ST_HALT);
            warn        <= (tec_nx > LIM_WARN) || (rec_nx > LIM_WARN);
        end
    end

    assign cnt_en = (state_q == ST_ACTIVE) || (state_q == ST_PASSIVE);

endmodule

// File: rtl/can_fc_tracker.sv
// Top level: two error counters, bus-off recovery counter, state machine.
module can_fc_tracker
    import can_fc_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int TX_STEP     = 8,
    parameter int RX_STEP     = 1,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255,
    parameter int RECOV_SEQS  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             idle_seq,
    input  logic             restart_req,
    input  logic             stop_sel,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic             err_active,
    output logic             err_passive,
    output logic             bus_off,
    output logic             warn,
    output logic             halt_ack
);

    fc_state_e        state_q;
    logic             cnt_en;
    logic             recov_done;
    logic [CNT_W-1:0] tec_nx;
    logic [CNT_W-1:0] rec_nx;

    can_fc_errcnt #(.W(CNT_W), .STEP(TX_STEP)) u_tec (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cnt_en),
        .clr    (recov_done),
        .inc    (tx_err),
        .dec    (tx_ok),
        .cnt_nx (tec_nx),
        .cnt_q  (tec)
    );

    can_fc_errcnt #(.W(CNT_W), .STEP(RX_STEP)) u_rec (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cnt_en),
        .clr    (recov_done),
        .inc    (rx_err),
        .dec    (rx_ok),
        .cnt_nx (rec_nx),
        .cnt_q  (rec)
    );

    can_fc_recovery #(.SEQS(RECOV_SEQS)) u_recov (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (state_q == ST_BUSOFF),
        .seq_pulse (idle_seq),
        .done      (recov_done)
    );

    can_fc_fsm #(
        .CNT_W       (CNT_W),
        .WARN_LIM    (WARN_LIM),
        .PASSIVE_LIM (PASSIVE_LIM),
        .BUSOFF_LIM  (BUSOFF_LIM)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tec_nx      (tec_nx),
        .rec_nx      (rec_nx),
        .recov_done  (recov_done),
        .stop_sel    (stop_sel),
        .restart_req (restart_req),
        .state_q     (state_q),
        .cnt_en      (cnt_en),
        .err_active  (err_active),
        .err_passive (err_passive),
        .bus_off     (bus_off),
        .warn        (warn),
        .halt_ack    (halt_ack)
    );

endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_err,
    input logic             rx_err,
    input logic             restart_req,
    input logic [CNT_W-1:0] tec,
    input logic [CNT_W-1:0] rec,
    input logic             err_active,
    input logic             err_passive,
    input logic             bus_off,
    input logic             halt_ack
);

    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({err_active, err_passive, bus_off, halt_ack}) == 1); // R5

    AST_ACTIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        err_active |-> (tec <= 127 && rec <= 127)); // R6

    AST_PASSIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        err_passive |-> ((tec > 127 || rec > 127) && tec <= 255)); // R5

    AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tec > 255) |-> bus_off); // R7

    AST_BUSOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && $past(bus_off)) |-> ($stable(tec) && $stable(rec))); // R7

    AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && (err_active || err_passive)) |=> (tec == $past(tec) + 9'd8)); // R2

    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        halt_ack |-> (tec == 0 && rec == 0)); // R10

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_ack && !restart_req) |=> halt_ack); // R10

    AST_RX_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && rec == 511) |=> (rec == 511)); // R11

endmodule

bind can_fc_tracker can_fc_checker #(.CNT_W(9)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_err      (tx_err),
    .rx_err      (rx_err),
    .restart_req (restart_req),
    .tec         (tec),
    .rec         (rec),
    .err_active  (err_active),
    .err_passive (err_passive),
    .bus_off     (bus_off),
    .halt_ack    (halt_ack)
);

// File: tb/can_fc_tracker_test.sv
`timescale 1ns/1ps
module can_fc_tracker_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0;
    logic idle_seq = 0, restart_req = 0, stop_sel = 0;
    logic [8:0] tec, rec;
    logic err_active, err_passive, bus_off, warn, halt_ack;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model: 0 active, 1 passive, 2 bus-off, 3 halt
    int m_tec = 0, m_rec = 0, m_st = 0, m_seq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_fc_tracker uut (
        .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .rx_err(rx_err),
        .tx_ok(tx_ok), .rx_ok(rx_ok), .idle_seq(idle_seq),
        .restart_req(restart_req), .stop_sel(stop_sel),
        .tec(tec), .rec(rec), .err_active(err_active),
        .err_passive(err_passive), .bus_off(bus_off), .warn(warn),
        .halt_ack(halt_ack)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tec = 0; m_rec = 0; m_st = 0; m_seq = 0;
        end else if (m_st <= 1) begin
            if (tx_err)                 m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
            else if (tx_ok && m_tec > 0) m_tec = m_tec - 1;
            if (rx_err)                 m_rec = (m_rec + 1 > 511) ? 511 : m_rec + 1;
            else if (rx_ok && m_rec > 0) m_rec = m_rec - 1;
            if (m_tec > 255)                    m_st = 2;
            else if (m_tec > 127 || m_rec > 127) m_st = 1;
            else                                m_st = 0;
            m_seq = 0;
        end else if (m_st == 2) begin
            if (idle_seq) m_seq = m_seq + 1;
            if (m_seq == 128) begin
                m_tec = 0; m_rec = 0; m_seq = 0;
                m_st = stop_sel ? 3 : 0;
            end
        end else if (restart_req) begin
            m_st = 0;
        end
    end

    // per-cycle comparison against the model (R12 alignment)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_vec++;
            if (int'(tec) != m_tec || int'(rec) != m_rec ||
                err_active != (m_st == 0) || err_passive != (m_st == 1) ||
                bus_off != (m_st == 2) || halt_ack != (m_st == 3) ||
                warn != (m_tec > 96 || m_rec > 96)) begin
                n_bad++;
                $display("FAIL R12 model: tec=%0d rec=%0d a/p/b/h/w=%b%b%b%b%b exp tec=%0d rec=%0d st=%0d",
                         tec, rec, err_active, err_passive, bus_off, halt_ack, warn,
                         m_tec, m_rec, m_st);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one strobe combination for n cycles, end on a falling edge
    task automatic drive(input bit te, input bit re, input bit to, input bit ro,
                         input bit id, input bit rs, input int n);
        @(negedge clk);
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; idle_seq = id; restart_req = rs;
        repeat (n) @(negedge clk);
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; idle_seq = 0; restart_req = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tec == 0 && rec == 0 && err_active && !warn && !bus_off && !halt_ack, "R1", tec, 0);
        rst_n = 1;
        @(negedge clk);
        chk(err_active && !err_passive, "R1", err_active, 1);

        drive(1, 0, 0, 0, 0, 0, 1);
        chk(tec == 8, "R2", tec, 8);
        drive(1, 0, 1, 0, 0, 0, 1);
        chk(tec == 16, "R2", tec, 16);
        drive(0, 0, 1, 1, 0, 0, 20);
        chk(tec == 0 && rec == 0, "R3", tec, 0);

        drive(0, 1, 0, 0, 0, 0, 96);
        chk(!warn && rec == 96, "R4", warn, 0);
        drive(0, 1, 0, 0, 0, 0, 1);
        chk(warn && rec == 97 && err_active, "R4", warn, 1);
        drive(0, 1, 0, 0, 0, 0, 31);
        chk(err_passive && rec == 128, "R5", err_passive, 1);
        drive(0, 0, 0, 1, 0, 0, 1);
        chk(err_active && rec == 127, "R6", err_active, 1);

        drive(0, 1, 0, 0, 0, 0, 1);
        drive(1, 0, 0, 0, 0, 0, 31);
        chk(err_passive && tec == 248, "R5", tec, 248);
        drive(1, 0, 0, 0, 0, 0, 1);
        chk(bus_off && tec == 256, "R7", tec, 256);
        drive(1, 1, 1, 1, 0, 0, 5);
        chk(tec == 256 && rec == 128, "R7", rec, 128);

        stop_sel = 0;
        drive(0, 0, 0, 0, 1, 0, 127);
        chk(bus_off, "R8", bus_off, 1);
        drive(0, 0, 0, 0, 0, 1, 1);
        chk(bus_off && !err_active, "R10", bus_off, 1);
        drive(0, 0, 0, 0, 1, 0, 1);
        chk(err_active && !bus_off && tec == 0 && rec == 0, "R9", err_active, 1);

        drive(1, 0, 0, 0, 0, 0, 32);
        chk(bus_off, "R7", bus_off, 1);
        stop_sel = 1;
        drive(0, 0, 0, 0, 1, 0, 128);
        chk(halt_ack && !err_active && !err_passive && !bus_off, "R10", halt_ack, 1);
        drive(1, 1, 0, 0, 0, 0, 3);
        chk(halt_ack && tec == 0 && rec == 0, "R10", tec, 0);
        drive(0, 0, 0, 0, 0, 1, 1);
        chk(err_active && !halt_ack, "R10", err_active, 1);
        stop_sel = 0;

        drive(0, 1, 0, 0, 0, 0, 520);
        chk(rec == 511 && err_passive, "R11", rec, 511);
        drive(0, 0, 0, 1, 0, 0, 511);
        chk(rec == 0 && err_active, "R3", rec, 0);

        // random mix, checked each cycle by the model
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            tx_err      = ($urandom_range(0, 3) == 0);
            tx_ok       = ($urandom_range(0, 3) == 0);
            rx_err      = ($urandom_range(0, 4) == 0);
            rx_ok       = ($urandom_range(0, 2) == 0);
            idle_seq    = ($urandom_range(0, 1) == 0);
            restart_req = ($urandom_range(0, 15) == 0);
            stop_sel    = ($urandom_range(0, 1) == 0);
        end
        @(negedge clk);
        tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0; idle_seq = 0; restart_req = 0;
        @(negedge clk);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule